// File: doc/BRIEF.md
# Four-Way Write-Back Word Cache

This block is a small data cache placed between the load/store port of a pipelined processor and a slow main memory. It holds single 32-bit words in 16 sets of four ways. Each way keeps its own tag, a valid flag and a dirty flag, and each set keeps a two-bit record of its most recently used way. Loads that hit return their word in the same cycle. Stores only change the cache and mark the word dirty. Main memory is touched only to fetch a word on a load miss, or to write back a dirty word that is being evicted.

Every main-memory transfer holds the processor stall for a fixed window of six cycles, counted from the cycle in which the miss is detected. A load that must first evict a dirty word pays two windows back to back. The processor keeps its request on the port until the stall drops. In the cycle where the stall drops, a missed load finds its word on the read-data output. A debug input makes every lookup report a miss, so that uncached timing can be measured without making the contents incoherent.

Top module: `wb_assoc_cache`

## Requirements
- R1: Reset clears every valid and dirty flag. After reset, with no request present, the stall and both memory strobes are low, and the first load of any address misses.
- R2: Bits [1:0] of the processor address are ignored. Bits [5:2] select the set and bits [31:6] form the tag. A fill drives `mem_addr` with the word address `cpu_addr[31:2]`.
- R3: A load or store whose set holds a valid way with an equal tag raises `cpu_hit` in the same cycle with the stall low. For a load, `cpu_rdata` carries the stored word in that cycle.
- R4: A load miss whose victim is not dirty holds the stall high for exactly 6 cycles, with `mem_rd` high during them. In the next cycle the stall is low, `cpu_hit` is low and `cpu_rdata` carries the fetched word.
- R5: A store that hits, or that lands in an empty or clean way, completes with the stall low and no memory strobe. The stored word is marked dirty, so its later eviction causes a write-back.
- R6: On allocation, the lowest-numbered way whose valid flag is 0 is used first.
- R7: When all four ways of the set are valid, the victim is the way one above the most recently used way, modulo 4. The most recently used way is the last way that hit or was filled.
- R8: A dirty victim is written to memory before it is replaced. `mem_wr` stays high for 6 stall cycles, carrying the victim's word address and data. A clean victim is overwritten with no memory access.
- R9: A load miss with a dirty victim stalls for 12 cycles: the write-back first, then the fill. The fetched word is stored clean.
- R10: While `force_miss` is high, `cpu_hit` stays low. A way that already holds the address becomes the target, so a dirty copy is written back before it is refetched or overwritten.
- R11: `mem_rd` and `mem_wr` are never high together, and each run of either strobe lasts exactly 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Load request, held until the stall drops |
| cpu_wr | input | 1 | Store request, held until the stall drops |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data |
| cpu_hit | output | 1 | Lookup hit in the current cycle |
| cpu_stall | output | 1 | Processor must hold its request |
| force_miss | input | 1 | Debug: every lookup reports a miss |
| mem_addr | output | 30 | Main-memory word address |
| mem_rd | output | 1 | Main-memory read strobe |
| mem_wr | output | 1 | Main-memory write strobe |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Fill data, sampled in the last window cycle |

## Verification
The bench builds the block with its default values: 16 sets, four ways and a six-cycle memory window. With these values a single set can be filled and then churned through more than one full round of evictions using small tag values. This makes the rotating victim order, the clean-versus-dirty choice and the twelve-cycle write-back-then-fill path visible at the ports. Because the window is only six cycles, the stall counts can be checked as exact numbers for every access. The forced-miss cases and a mid-run reset fit in the same short run.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    // Controller sequence: lookup, write-back of a dirty victim,
    // fill from memory, and one cycle that hands the result over.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2,
        ST_DONE  = 2'd3
    } ctl_state_e;

    localparam int MEM_WINDOW_DEFAULT = 6;

endpackage

// File: rtl/wbc_lookup.sv
module wbc_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 26,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS*TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]       set_valid,
    input  logic [TAG_W-1:0]      req_tag,
    output logic [WAYS-1:0]       match,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);

    // One comparator per way
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = set_valid[g] && (set_tags[g*TAG_W +: TAG_W] == req_tag);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) hit_way = WAY_W'(i);
        end
    end

endmodule

// File: rtl/wbc_victim_sel.sv
module wbc_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  match,
    input  logic             force_miss,
    input  logic [WAY_W-1:0] mru,
    output logic [WAY_W-1:0] way
);

    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] match_way;
    logic [WAY_W-1:0] rot_way;
    logic             free_any;

    assign free_any = ~&valid;

    always_comb begin
        free_way  = '0;
        match_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) free_way  = WAY_W'(i);
            if (match[i])  match_way = WAY_W'(i);
        end
    end

    // Way one above the most recent, wrapping at the way count
    assign rot_way = (mru == WAY_W'(WAYS - 1)) ? '0 : mru + WAY_W'(1);

    always_comb begin
        if (force_miss && |match) way = match_way;
        else if (free_any)        way = free_way;
        else                      way = rot_way;
    end

endmodule

// File: rtl/wbc_mem_timer.sv
module wbc_mem_timer #(
    parameter int WINDOW = 6,
    localparam int CNT_W = $clog2(WINDOW)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);

    logic [CNT_W-1:0] cnt_q;

    assign last = run && (cnt_q == CNT_W'(WINDOW - 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (last) cnt_q <= '0;
        else if (run)  cnt_q <= cnt_q + CNT_W'(1);
        else           cnt_q <= '0;
    end

    // A strobe that started a window must stay up until the window ends
    assert_no_abort_R11: assert property (@(posedge clk) disable iff (rst)
        (run && !last) |=> run);

endmodule

// File: rtl/wb_assoc_cache.sv
module wb_assoc_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int SETS    = 16,
    parameter int WAYS    = 4,
    parameter int MEM_LAT = MEM_WINDOW_DEFAULT,
    localparam int OFF_W   = 2,
    localparam int SET_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int TAG_W   = ADDR_W - SET_W - OFF_W,
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_hit,
    output logic               cpu_stall,
    input  logic               force_miss,
    output logic [WADDR_W-1:0] mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);

    localparam int LEN_W = $clog2(MEM_LAT + 1) + 1;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SET_W-1:0]  set;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [WAY_W-1:0]  way;
    } pend_req_t;

    // ---------------- storage ----------------
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [WAY_W-1:0]  mru_q   [SETS];

    ctl_state_e        state_q;
    pend_req_t         req_q;
    logic [DATA_W-1:0] done_data_q;

    // ---------------- address split ----------------
    logic [SET_W-1:0] cur_set;
    logic [TAG_W-1:0] cur_tag;
    logic             unused_offset;

    assign cur_set       = cpu_addr[OFF_W +: SET_W];
    assign cur_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = ^cpu_addr[OFF_W-1:0];

    // ---------------- lookup ----------------
    logic [WAYS*TAG_W-1:0] cur_tags;
    logic [WAYS-1:0]       match;
    logic                  raw_hit;
    logic [WAY_W-1:0]      hit_way;
    logic [WAY_W-1:0]      vic_way;

    for (genvar g = 0; g < WAYS; g++) begin : g_tags
        assign cur_tags[g*TAG_W +: TAG_W] = tag_q[cur_set][g];
    end

    wbc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .set_tags  (cur_tags),
        .set_valid (valid_q[cur_set]),
        .req_tag   (cur_tag),
        .match     (match),
        .hit       (raw_hit),
        .hit_way   (hit_way)
    );

    wbc_victim_sel #(.WAYS(WAYS)) u_victim (
        .valid      (valid_q[cur_set]),
        .match      (match),
        .force_miss (force_miss),
        .mru        (mru_q[cur_set]),
        .way        (vic_way)
    );

    // ---------------- decisions in the lookup cycle ----------------
    logic idle, access, eff_hit, vic_dirty;
    logic start_wb, start_fill, direct_store;

    assign idle         = (state_q == ST_IDLE);
    assign access       = idle && (cpu_rd || cpu_wr);
    assign eff_hit      = raw_hit && !force_miss;
    assign vic_dirty    = valid_q[cur_set][vic_way] && dirty_q[cur_set][vic_way];
    assign start_wb     = access && !eff_hit && vic_dirty;
    assign start_fill   = access && !eff_hit && !vic_dirty && !cpu_wr;
    assign direct_store = access && !eff_hit && !vic_dirty && cpu_wr;

    // ---------------- memory side ----------------
    logic [SET_W-1:0] sel_set;
    logic [WAY_W-1:0] sel_way;
    logic             win_last;

    assign sel_set = idle ? cur_set : req_q.set;
    assign sel_way = idle ? vic_way : req_q.way;

    assign mem_wr    = start_wb   || (state_q == ST_EVICT);
    assign mem_rd    = start_fill || (state_q == ST_FILL);
    assign mem_wdata = data_q[sel_set][sel_way];
    assign mem_addr  = mem_wr ? {tag_q[sel_set][sel_way], sel_set}
                     : (idle ? {cur_tag, cur_set} : {req_q.tag, req_q.set});

    wbc_mem_timer #(.WINDOW(MEM_LAT)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (mem_rd || mem_wr),
        .last (win_last)
    );

    // ---------------- processor side ----------------
    assign cpu_stall = start_wb || start_fill ||
                       (state_q == ST_EVICT) || (state_q == ST_FILL);
    assign cpu_hit   = access && eff_hit;
    assign cpu_rdata = (state_q == ST_DONE) ? done_data_q
                     : (cpu_hit ? data_q[cur_set][hit_way] : '0);

    // ---------------- state and array updates ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            req_q       <= '0;
            done_data_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                mru_q[s]   <= '0;
            end
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cpu_hit) begin
                        mru_q[cur_set] <= hit_way;
                        if (cpu_wr) begin
                            data_q[cur_set][hit_way]  <= cpu_wdata;
                            dirty_q[cur_set][hit_way] <= 1'b1;
                        end
                    end else if (direct_store) begin
                        tag_q[cur_set][vic_way]   <= cur_tag;
                        data_q[cur_set][vic_way]  <= cpu_wdata;
                        valid_q[cur_set][vic_way] <= 1'b1;
                        dirty_q[cur_set][vic_way] <= 1'b1;
                        mru_q[cur_set]            <= vic_way;
                    end else if (start_wb || start_fill) begin
                        req_q.tag   <= cur_tag;
                        req_q.set   <= cur_set;
                        req_q.wr    <= cpu_wr;
                        req_q.wdata <= cpu_wdata;
                        req_q.way   <= vic_way;
                        state_q     <= start_wb ? ST_EVICT : ST_FILL;
                    end
                end
                ST_EVICT: begin
                    if (win_last) begin
                        if (req_q.wr) begin
                            tag_q[req_q.set][req_q.way]   <= req_q.tag;
                            data_q[req_q.set][req_q.way]  <= req_q.wdata;
                            valid_q[req_q.set][req_q.way] <= 1'b1;
                            dirty_q[req_q.set][req_q.way] <= 1'b1;
                            mru_q[req_q.set]              <= req_q.way;
                            state_q                       <= ST_DONE;
                        end else begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (win_last) begin
                        tag_q[req_q.set][req_q.way]   <= req_q.tag;
                        data_q[req_q.set][req_q.way]  <= mem_rdata;
                        valid_q[req_q.set][req_q.way] <= 1'b1;
                        dirty_q[req_q.set][req_q.way] <= 1'b0;
                        mru_q[req_q.set]              <= req_q.way;
                        done_data_q                   <= mem_rdata;
                        state_q                       <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [LEN_W-1:0] rd_len_q, wr_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_len_q <= '0;
            wr_len_q <= '0;
        end else begin
            rd_len_q <= mem_rd ? rd_len_q + LEN_W'(1) : '0;
            wr_len_q <= mem_wr ? wr_len_q + LEN_W'(1) : '0;
        end
    end

    assert_hit_no_stall_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> !cpu_stall);

    assert_forced_miss_R10: assert property (@(posedge clk) disable iff (rst)
        force_miss |-> !cpu_hit);

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_rd_window_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_rd) |-> (rd_len_q == LEN_W'(MEM_LAT)));

    assert_wr_window_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr) |-> (wr_len_q == LEN_W'(MEM_LAT)));

    assert_release_after_fill_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_rd) |-> !cpu_stall);

endmodule

// File: tb/tb_wb_assoc_cache.sv
module tb_wb_assoc_cache;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_rd, cpu_wr, force_miss;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_hit, cpu_stall;
    logic [29:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    wb_assoc_cache dut (
        .clk(clk), .rst(rst),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .force_miss(force_miss),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // ---------------- memory model and golden image ----------------
    logic [31:0] mem    [1024];
    logic [31:0] golden [1024];

    function automatic logic [31:0] init_word(int i);
        return 32'hA500_0000 ^ (32'(i) * 32'h0001_0101);
    endfunction

    assign mem_rdata = mem[mem_addr[9:0]];

    int          wr_events, bad_overlap, bad_run;
    int          rd_run, wr_run;
    logic [29:0] last_wr_addr;
    logic [31:0] last_wr_data;
    logic        wr_prev;

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (!rst) begin
            if (mem_wr && !wr_prev) begin
                wr_events++;
                last_wr_addr = mem_addr;
                last_wr_data = mem_wdata;
            end
            if (mem_rd && mem_wr) bad_overlap++;
            if (mem_rd) rd_run++;
            else begin
                if (rd_run != 0 && rd_run != 6) bad_run++;
                rd_run = 0;
            end
            if (mem_wr) wr_run++;
            else begin
                if (wr_run != 0 && wr_run != 6) bad_run++;
                wr_run = 0;
            end
        end
        wr_prev = mem_wr;
    end

    // ---------------- bookkeeping ----------------
    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(int tag, int set, int off);
        return (32'(tag) << 6) | (32'(set) << 2) | 32'(off);
    endfunction

    function automatic int widx(logic [31:0] a);
        return int'(a[11:2]);
    endfunction

    task automatic do_acc(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                          input bit frc, output int stalls, output logic hit,
                          output logic [31:0] rdata, output logic mrd0,
                          output logic [29:0] maddr0);
        cpu_rd = !wr; cpu_wr = wr; cpu_addr = addr; cpu_wdata = wd; force_miss = frc;
        #1;
        hit = cpu_hit; mrd0 = mem_rd; maddr0 = mem_addr;
        stalls = 0;
        while (cpu_stall && stalls < 60) begin
            @(negedge clk); #1;
            stalls++;
        end
        rdata = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0; force_miss = 1'b0;
    endtask

    // ---------------- stimulus table (all rows in set 3) ----------------
    typedef struct packed {
        logic       wr;
        logic [7:0] tag;
        logic [1:0] off;
        logic       frc;
        logic [4:0] stalls;
        logic       hit;
        logic       wd;
        logic [7:0] vtag;
    } row_t;

    localparam int NROWS = 19;
    localparam row_t VEC [NROWS] = '{
        '{1'b0, 8'd1,  2'd0, 1'b0, 5'd6,  1'b0, 1'b0, 8'd0},  // R1 cold miss
        '{1'b0, 8'd1,  2'd0, 1'b0, 5'd0,  1'b1, 1'b0, 8'd0},  // R3 hit
        '{1'b0, 8'd1,  2'd2, 1'b0, 5'd0,  1'b1, 1'b0, 8'd0},  // R2 offset ignored
        '{1'b1, 8'd2,  2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 8'd0},  // R5 R6 way1
        '{1'b1, 8'd3,  2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 8'd0},  // R6 way2
        '{1'b1, 8'd4,  2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 8'd0},  // R6 way3
        '{1'b0, 8'd2,  2'd0, 1'b0, 5'd0,  1'b1, 1'b0, 8'd0},  // R3 mru=1
        '{1'b1, 8'd5,  2'd0, 1'b0, 5'd6,  1'b0, 1'b1, 8'd3},  // R7 R8 evict way2
        '{1'b0, 8'd6,  2'd0, 1'b0, 5'd12, 1'b0, 1'b1, 8'd4},  // R9 evict way3
        '{1'b0, 8'd7,  2'd0, 1'b0, 5'd6,  1'b0, 1'b0, 8'd0},  // R8 clean way0
        '{1'b0, 8'd8,  2'd0, 1'b0, 5'd12, 1'b0, 1'b1, 8'd2},  // R9 way1
        '{1'b0, 8'd9,  2'd0, 1'b0, 5'd12, 1'b0, 1'b1, 8'd5},  // R9 way2
        '{1'b0, 8'd10, 2'd0, 1'b0, 5'd6,  1'b0, 1'b0, 8'd0},  // R9 fetched clean
        '{1'b0, 8'd3,  2'd0, 1'b0, 5'd6,  1'b0, 1'b0, 8'd0},  // R8 written-back value
        '{1'b1, 8'd3,  2'd0, 1'b0, 5'd0,  1'b1, 1'b0, 8'd0},  // R5 store hit
        '{1'b0, 8'd3,  2'd0, 1'b1, 5'd12, 1'b0, 1'b1, 8'd3},  // R10 dirty match
        '{1'b1, 8'd3,  2'd1, 1'b1, 5'd0,  1'b0, 1'b0, 8'd0},  // R10 clean match
        '{1'b0, 8'd3,  2'd0, 1'b1, 5'd12, 1'b0, 1'b1, 8'd3},  // R10 dirty again
        '{1'b0, 8'd3,  2'd3, 1'b0, 5'd0,  1'b1, 1'b0, 8'd0}   // R3 final hit
    };

    // ---------------- watchdog ----------------
    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int          st;
        logic        h, mrd0;
        logic [31:0] rd, a, wdat;
        logic [29:0] ma0;
        int          wbefore;

        for (int i = 0; i < 1024; i++) begin
            mem[i]    = init_word(i);
            golden[i] = init_word(i);
        end
        wr_events = 0; bad_overlap = 0; bad_run = 0; rd_run = 0; wr_run = 0;
        wr_prev = 1'b0; last_wr_addr = '0; last_wr_data = '0;
        cpu_rd = 0; cpu_wr = 0; force_miss = 0; cpu_addr = '0; cpu_wdata = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;

        // R1: quiet after reset
        check(!cpu_stall && !mem_rd && !mem_wr && !cpu_hit, "R1", "idle outputs after reset",
              {28'd0, cpu_stall, mem_rd, mem_wr, cpu_hit}, 32'd0);
        @(negedge clk);

        for (int r = 0; r < NROWS; r++) begin
            a       = addr_of(int'(VEC[r].tag), 3, int'(VEC[r].off));
            wdat    = 32'hD000_0000 | (32'(r) << 8) | 32'(VEC[r].tag);
            wbefore = wr_events;
            do_acc(VEC[r].wr, a, wdat, VEC[r].frc, st, h, rd, mrd0, ma0);
            check(st == int'(VEC[r].stalls), "R4/R7/R9", $sformatf("row %0d stall cycles", r),
                  32'(st), 32'(VEC[r].stalls));
            check(h == VEC[r].hit, "R3/R10", $sformatf("row %0d hit flag", r),
                  32'(h), 32'(VEC[r].hit));
            if (!VEC[r].wr)
                check(rd == golden[widx(a)], "R3/R4", $sformatf("row %0d load data", r),
                      rd, golden[widx(a)]);
            check((wr_events - wbefore) == int'(VEC[r].wd), "R5/R6/R8",
                  $sformatf("row %0d write-back count", r),
                  32'(wr_events - wbefore), 32'(VEC[r].wd));
            if (VEC[r].wd) begin
                check(last_wr_addr == 30'(widx(addr_of(int'(VEC[r].vtag), 3, 0))) ||
                      last_wr_addr[29:10] != 0 ? last_wr_addr == (addr_of(int'(VEC[r].vtag), 3, 0) >> 2) : 1'b0,
                      "R8", $sformatf("row %0d victim address", r),
                      32'(last_wr_addr), addr_of(int'(VEC[r].vtag), 3, 0) >> 2);
                check(last_wr_data == golden[widx(addr_of(int'(VEC[r].vtag), 3, 0))],
                      "R8", $sformatf("row %0d victim data", r),
                      last_wr_data, golden[widx(addr_of(int'(VEC[r].vtag), 3, 0))]);
            end
            if (VEC[r].wr) golden[widx(a)] = wdat;
        end

        // R2: fill address is the word address, set 9 tag 20, offset 1
        a = addr_of(20, 9, 1);
        do_acc(1'b0, a, 32'd0, 1'b0, st, h, rd, mrd0, ma0);
        check(mrd0 == 1'b1 && ma0 == a[31:2], "R2", "fill word address",
              32'(ma0), a >> 2);
        check(st == 6, "R4", "other set cold miss stall", 32'(st), 32'd6);
        check(rd == golden[widx(a)], "R4", "other set fill data", rd, golden[widx(a)]);

        // R1: reset empties a cache that held tag 10 in set 3 (clean)
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        a = addr_of(10, 3, 0);
        do_acc(1'b0, a, 32'd0, 1'b0, st, h, rd, mrd0, ma0);
        check(st == 6 && !h, "R1", "miss after mid-run reset", 32'(st), 32'd6);
        check(rd == golden[widx(a)], "R1", "data after mid-run reset", rd, golden[widx(a)]);
        do_acc(1'b0, a, 32'd0, 1'b0, st, h, rd, mrd0, ma0);
        check(st == 0 && h, "R3", "hit after refill", 32'(st), 32'd0);

        // R11: strobe discipline observed throughout
        check(bad_overlap == 0, "R11", "read and write strobes together", 32'(bad_overlap), 32'd0);
        check(bad_run == 0, "R11", "strobe run not six cycles", 32'(bad_run), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule